// File: doc/BRIEF.md
# Fixed-Frequency Pulse-Width Modulator

This block produces a single pulse-width-modulated output whose period is fixed at elaboration time. The period length in clock cycles is the ratio of two parameters: the frequency of the incoming clock and the wanted output frequency. The high time within each period comes from a duty word that can change while the block runs. The width of that word, and so the duty resolution, is set by a third parameter.

An active-low enable gates the block. While enable is deasserted, the output stays low and the period restarts from its first cycle. A new duty word takes effect only when a period begins, so a period is never cut short or stretched partway through. A slow instance can serve as a visible tick, for example to advance a counter that drives a display.

Top module: `pwm_gen`

## Requirements
- R1: With the block enabled, the period counter runs from 0 to PERIOD-1, where PERIOD = CLK_HZ / OUT_HZ, and then wraps to 0. The output pattern therefore repeats every PERIOD cycles.
- R2: For a duty word d that is not all ones, the high time is T = floor(d * PERIOD / 2^DUTY_BITS). The output is registered, so it is high in the cycle after each cycle whose counter value is below T, and low otherwise.
- R3: While `en_n` is 1 at a clock edge, `pwm` is 0 after that edge and the counter is held at 0. The first enabled edge then starts a fresh period at count 0.
- R4: The duty word is sampled only in the cycle where the counter is 0. A change at any other count has no effect on the output until the next period starts.
- R5: A duty word of 0 gives an output that stays low for the whole period.
- R6: A duty word of all ones (full scale) gives an output that stays high for the whole period.
- R7: After a synchronous reset (`rst` = 1 at a clock edge), `pwm` is 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Enable, active low; 1 holds the output low |
| duty | input | DUTY_BITS | Duty word; all ones means constant high |
| pwm | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a duty change in the middle of a period. The output must keep the old high time until the counter wraps. To get there, the bench moves the duty word on every cycle within a period, and its reference model samples the word only at count 0. The bench also toggles the enable at different points in the period. This tests that each re-enable restarts the period and reloads the duty word, rather than resuming with a stale threshold.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Number of clock cycles in one output period.
    function automatic int unsigned period_cycles(input longint unsigned clk_hz,
                                                  input longint unsigned out_hz);
        return int'(clk_hz / out_hz);
    endfunction

    // High time in cycles for a given duty word.
    // A duty word of all ones maps to a full period.
    function automatic int unsigned high_cycles(input longint unsigned duty_val,
                                                input int unsigned     period,
                                                input int unsigned     bits);
        longint unsigned full;
        full = (64'd1 << bits) - 64'd1;
        if (duty_val == full) begin
            return period;
        end
        return int'((duty_val * longint'(period)) >> bits);
    endfunction

    // State of the period counter, handed to the downstream logic.
    typedef struct packed {
        logic start;   // counter is at 0 in this cycle
        logic run;     // enabled in this cycle
    } pwm_phase_t;

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_pkg::*;
#(
    parameter int unsigned PERIOD = 10,
    localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    output logic [CNT_W-1:0] cnt,
    output pwm_phase_t       phase
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst || en_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        phase.start = (cnt == '0);
        phase.run   = ~en_n;
    end
endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch
    import pwm_pkg::*;
#(
    parameter int unsigned DUTY_BITS = 8,
    parameter int unsigned PERIOD    = 10,
    localparam int unsigned THR_W    = $clog2(PERIOD + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pwm_phase_t           phase,
    input  logic [DUTY_BITS-1:0] duty,
    output logic [THR_W-1:0]     thr_q,
    output logic [THR_W-1:0]     thr_now
);
    logic [THR_W-1:0] thr_new;

    always_comb begin
        thr_new = THR_W'(high_cycles(longint'(duty), PERIOD, DUTY_BITS));
        thr_now = phase.start ? thr_new : thr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else begin
            thr_q <= thr_now;
        end
    end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  pwm_phase_t       phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [THR_W-1:0] thr_now,
    output logic             pwm
);
    localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic below;

    always_comb begin
        below = CMP_W'(cnt) < CMP_W'(thr_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm <= 1'b0;
        end else begin
            pwm <= phase.run & below;
        end
    end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_pkg::*;
#(
    parameter int unsigned    DUTY_BITS = 8,
    parameter longint unsigned CLK_HZ   = 50_000_000,
    parameter longint unsigned OUT_HZ   = 1_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_n,
    input  logic [DUTY_BITS-1:0] duty,
    output logic                 pwm
);
    localparam int unsigned PERIOD = period_cycles(CLK_HZ, OUT_HZ);
    localparam int unsigned CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int unsigned THR_W  = $clog2(PERIOD + 1);

    logic [CNT_W-1:0] cnt;
    logic [THR_W-1:0] thr_q;
    logic [THR_W-1:0] thr_now;
    pwm_phase_t       phase;

    pwm_period_ctr #(.PERIOD(PERIOD)) ctr_i (
        .clk   (clk),
        .rst   (rst),
        .en_n  (en_n),
        .cnt   (cnt),
        .phase (phase)
    );

    pwm_duty_latch #(.DUTY_BITS(DUTY_BITS), .PERIOD(PERIOD)) latch_i (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .duty    (duty),
        .thr_q   (thr_q),
        .thr_now (thr_now)
    );

    pwm_out_stage #(.CNT_W(CNT_W), .THR_W(THR_W)) out_i (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .cnt     (cnt),
        .thr_now (thr_now),
        .pwm     (pwm)
    );
endmodule

// File: rtl/pwm_gen_checker.sv
module pwm_gen_checker #(
    parameter int unsigned DUTY_BITS = 8,
    parameter int unsigned PERIOD    = 10,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned THR_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en_n,
    input logic [DUTY_BITS-1:0] duty,
    input logic                 pwm,
    input logic [CNT_W-1:0]     cnt,
    input logic [THR_W-1:0]     thr_q
);
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(PERIOD - 1));

    assert_off_when_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        en_n |=> (!pwm && cnt == '0));

    assert_hold_mid_period_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> $stable(thr_q));

    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (rst)
        (!en_n && cnt == '0 && duty == '0) |=> !pwm);

    assert_full_duty_high_R6: assert property (@(posedge clk) disable iff (rst)
        (!en_n && cnt == '0 && duty == '1) |=> pwm);

    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (!pwm && cnt == '0));
endmodule

bind pwm_gen pwm_gen_checker #(
    .DUTY_BITS (DUTY_BITS),
    .PERIOD    (PERIOD),
    .CNT_W     (CNT_W),
    .THR_W     (THR_W)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .en_n  (en_n),
    .duty  (duty),
    .pwm   (pwm),
    .cnt   (cnt),
    .thr_q (thr_q)
);

// File: tb/pwm_gen_tb_top.sv
module pwm_gen_tb_top;
    localparam int unsigned DB  = 3;
    localparam int unsigned PER = 10;
    localparam int unsigned FS  = (1 << DB) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_n = 1'b1;
    logic [DB-1:0] duty = '0;
    logic          pwm;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // reference model state
    int  m_cnt = 0;
    int  m_thr = 0;
    bit  m_pwm = 0;

    pwm_gen #(.DUTY_BITS(DB), .CLK_HZ(1000), .OUT_HZ(100)) dut_i (
        .clk  (clk),
        .rst  (rst),
        .en_n (en_n),
        .duty (duty),
        .pwm  (pwm)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic int exp_high(input int d);
        if (d == FS) return PER;
        return (d * PER) >> DB;
    endfunction

    always @(posedge clk) begin
        int athr;
        cycles++;
        if (rst) begin
            m_cnt = 0; m_thr = 0; m_pwm = 0;
        end else begin
            athr  = (m_cnt == 0) ? exp_high(int'(duty)) : m_thr;
            m_pwm = !en_n && (m_cnt < athr);
            m_thr = athr;
            if (en_n || m_cnt == PER - 1) m_cnt = 0;
            else m_cnt = m_cnt + 1;
        end
    end

    task automatic check(input string req);
        total++;
        if (pwm !== m_pwm) begin
            bad++;
            $display("FAIL %s: pwm=%0b expected=%0b cycle=%0d", req, pwm, m_pwm, cycles);
        end
    endtask

    // advance one cycle, then compare at the falling edge
    task automatic step(input string req);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        int hi;
        // R7: reset state
        repeat (3) step("R7");
        rst = 1'b0;
        repeat (2) step("R3");

        // R1 R2 R5 R6: sweep every duty word over three periods
        for (int d = 0; d <= FS; d++) begin
            duty = DB'(d);
            en_n = 1'b1;
            step("R3");
            en_n = 1'b0;
            hi = 0;
            for (int c = 0; c < 3 * PER; c++) begin
                step(d == 0 ? "R5" : (d == FS ? "R6" : "R2"));
                if (c >= PER && c < 2 * PER) hi += int'(pwm);
            end
            total++;
            if (hi != exp_high(d)) begin
                bad++;
                $display("FAIL R1: high count=%0d expected=%0d duty=%0d", hi, exp_high(d), d);
            end
        end

        // R4: change duty at every position inside the period
        for (int k = 0; k < 4 * PER; k++) begin
            duty = DB'((k * 5 + 3) % (FS + 1));
            step("R4");
        end

        // R3: toggle enable at varying points
        duty = DB'(5);
        for (int k = 1; k < PER + 3; k++) begin
            en_n = 1'b0;
            repeat (k) step("R3");
            en_n = 1'b1;
            duty = DB'(k % (FS + 1));
            repeat (2) step("R3");
        end

        // R7: reset in the middle of a period
        en_n = 1'b0;
        duty = '1;
        repeat (4) step("R6");
        rst = 1'b1;
        step("R7");
        rst = 1'b0;
        repeat (PER) step("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule